// File: doc/BRIEF.md
# On-the-fly Scalar Recoding Unit

This block holds a secret scalar of up to `MAX_BITS` bits and turns it into a stream of signed digits. It produces one digit each time the point-operation sequencer asks for one. No digit buffer is ever built. Each digit is derived from a running residue. The residue is then updated so that the next request sees the remaining part of the scalar. The digits come out least significant first, and the sequencer tests each digit to choose between a doubling alone or a doubling plus an addition or subtraction.

Software writes the scalar one `WORD_W`-bit word at a time while the unit is idle. A start pulse then selects the recoding for the run. Mode code 2 to 5 selects width-λ non-adjacent form with λ equal to the code. Any other code selects plain binary. After that, each request yields one digit, given as a sign and a magnitude. The final digit carries a flag, which is raised when the residue left behind is zero. The unit then falls back to idle. A λ-NAF run can be one digit longer than the scalar.

The controller has four named states. IDLE accepts word writes and a start pulse; start moves it to READY. READY waits for a request; a request moves it to CALC. In CALC the digit is formed and the residue updated; it always moves on to EMIT. EMIT shows the digit for one cycle, then returns to IDLE on the last digit and to READY otherwise.

Top module: `scalar_recoder`

## Requirements
- R1: After reset the unit is in IDLE with `dig_valid` and `dig_last` low, and a request in IDLE yields no digit.
- R2: A word write in IDLE places `wr_data` at scalar bits `[wr_idx*WORD_W +: WORD_W]`. Writes made while a run is in progress leave the run's digits unchanged.
- R3: A start pulse in IDLE latches the width λ for the run: codes 2 to 5 give λ-NAF of that width, and every other code (0, 1, 6, 7) gives binary.
- R4: In binary mode each digit is the residue's least significant bit, with sign 0. The residue then shifts right by one.
- R5: In λ-NAF mode an odd residue r gives the digit d = r mod 2^λ, less 2^λ when that value is at least 2^(λ−1). A negative d has sign 1 and magnitude −d. The residue becomes (r − d)/2.
- R6: An even residue gives a zero digit (sign 0, magnitude 0) in every mode, and the residue halves.
- R7: A request sampled in READY makes `dig_valid` high for exactly one cycle, two clock edges later. A request held or repeated while in CALC or EMIT produces no further digit.
- R8: `dig_last` is high with `dig_valid` exactly when the residue after that digit is zero. A zero scalar yields a single zero digit with the flag. A run never exceeds `MAX_BITS+1` digits.
- R9: In λ-NAF mode every nonzero digit is followed by at least λ−1 zero digits.
- R10: The sum of digit_i·2^i over a run equals the loaded scalar.
- R11: A start pulse outside IDLE is ignored and does not change the width in use.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Scalar word write strobe (taken in IDLE only) |
| wr_idx | input | IDX_W | Index of the word being written |
| wr_data | input | WORD_W | Scalar word value |
| start | input | 1 | Begin a recoding run (taken in IDLE only) |
| mode_sel | input | LAM_W | Width code: 2..LAM_MAX for λ-NAF, other values binary |
| dig_req | input | 1 | Request for the next digit |
| dig_valid | output | 1 | Digit outputs are valid this cycle |
| dig_sign | output | 1 | Digit sign, 1 for negative |
| dig_mag | output | MAG_W | Digit magnitude |
| dig_last | output | 1 | This digit is the final one of the run |

## Verification
A request sampled at one rising edge moves the unit to CALC; the next edge moves it to EMIT. The digit is therefore checked on the falling edge after the second edge, and `dig_valid` is checked low on the falling edge in between and on the one that follows. A start pulse takes effect at one edge, so the first request goes in on the next falling edge. A reference model in the bench, built on a wide residue and integer arithmetic, predicts the sign, magnitude and last flag of every digit. The bench also accumulates the weighted sum of the digits and checks the run length and the λ−1 zero spacing. To exercise R2, R7 and R11, stray writes, starts and held requests are driven during the CALC and EMIT cycles of a run.

// File: rtl/srec_pkg.sv
package srec_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READY,
        ST_CALC,
        ST_EMIT
    } srec_state_t;

    localparam int unsigned LAM_MAX_DEF = 5;
endpackage

// File: rtl/srec_digit_unit.sv
module srec_digit_unit #(
    parameter int unsigned RES_W   = 257,
    parameter int unsigned LAM_MAX = 5,
    parameter int unsigned LAM_W   = 3,
    parameter int unsigned MAG_W   = 4
) (
    input  logic [RES_W-1:0] res,
    input  logic [LAM_W-1:0] lam,
    output logic             dsign,
    output logic [MAG_W-1:0] dmag,
    output logic [RES_W-1:0] res_next
);
    localparam int unsigned WIN_W = LAM_MAX + 1;

    logic [WIN_W-1:0] full;
    logic [WIN_W-1:0] half;
    logic [WIN_W-1:0] win;
    logic [WIN_W-1:0] neg_mag;
    logic [RES_W-1:0] adj;

    always_comb begin
        full    = WIN_W'(1) << lam;
        half    = full >> 1;
        win     = {1'b0, res[LAM_MAX-1:0]} & (full - WIN_W'(1));
        neg_mag = full - win;
        dsign   = 1'b0;
        dmag    = '0;
        if (res[0]) begin
            if (lam <= LAM_W'(1)) begin
                dmag = MAG_W'(1);
            end else if (win >= half) begin
                dsign = 1'b1;
                dmag  = MAG_W'(neg_mag);
            end else begin
                dmag = MAG_W'(win);
            end
        end
        adj      = dsign ? (res + RES_W'(dmag)) : (res - RES_W'(dmag));
        res_next = adj >> 1;
    end
endmodule

// File: rtl/srec_residue.sv
module srec_residue #(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned NWORDS = 8,
    parameter int unsigned IDX_W  = 3,
    parameter int unsigned RES_W  = 257
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ok,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              upd_en,
    input  logic [RES_W-1:0]  res_next,
    output logic [RES_W-1:0]  res
);
    localparam int unsigned GUARD = NWORDS * WORD_W;

    for (genvar g = 0; g < NWORDS; g++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                res[g*WORD_W +: WORD_W] <= '0;
            end else if (upd_en) begin
                res[g*WORD_W +: WORD_W] <= res_next[g*WORD_W +: WORD_W];
            end else if (wr_ok && (wr_idx == IDX_W'(g))) begin
                res[g*WORD_W +: WORD_W] <= wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res[GUARD] <= 1'b0;
        end else if (upd_en) begin
            res[GUARD] <= res_next[GUARD];
        end else if (wr_ok) begin
            res[GUARD] <= 1'b0;
        end
    end
endmodule

// File: rtl/srec_ctrl.sv
module srec_ctrl
    import srec_pkg::*;
#(
    parameter int unsigned LAM_MAX = 5,
    parameter int unsigned LAM_W   = 3,
    parameter int unsigned MAG_W   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LAM_W-1:0] mode_sel,
    input  logic             dig_req,
    input  logic             res_zero,
    input  logic             calc_sign,
    input  logic [MAG_W-1:0] calc_mag,
    output logic [LAM_W-1:0] lam,
    output logic             wr_ok,
    output logic             upd_en,
    output logic             dig_valid,
    output logic             dig_sign,
    output logic [MAG_W-1:0] dig_mag,
    output logic             dig_last
);
    srec_state_t state_q, state_d;
    logic [LAM_W-1:0] lam_q;
    logic             sign_q;
    logic [MAG_W-1:0] mag_q;
    logic             mode_is_naf;

    assign mode_is_naf = (mode_sel >= LAM_W'(2)) && (mode_sel <= LAM_W'(LAM_MAX));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start)   state_d = ST_READY;
            ST_READY: if (dig_req) state_d = ST_CALC;
            ST_CALC:               state_d = ST_EMIT;
            ST_EMIT:               state_d = res_zero ? ST_IDLE : ST_READY;
            default:               state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lam_q  <= LAM_W'(1);
            sign_q <= 1'b0;
            mag_q  <= '0;
        end else begin
            if (state_q == ST_IDLE && start) begin
                lam_q <= mode_is_naf ? mode_sel : LAM_W'(1);
            end
            if (state_q == ST_CALC) begin
                sign_q <= calc_sign;
                mag_q  <= calc_mag;
            end
        end
    end

    always_comb begin
        wr_ok     = 1'b0;
        upd_en    = 1'b0;
        dig_valid = 1'b0;
        dig_last  = 1'b0;
        unique case (state_q)
            ST_IDLE:  wr_ok = 1'b1;
            ST_READY: ;
            ST_CALC:  upd_en = 1'b1;
            ST_EMIT: begin
                dig_valid = 1'b1;
                dig_last  = res_zero;
            end
            default: ;
        endcase
    end

    assign lam      = lam_q;
    assign dig_sign = sign_q;
    assign dig_mag  = mag_q;
endmodule

// File: rtl/scalar_recoder.sv
module scalar_recoder #(
    parameter int unsigned WORD_W   = 32,
    parameter int unsigned MAX_BITS = 256,
    parameter int unsigned LAM_MAX  = srec_pkg::LAM_MAX_DEF,
    localparam int unsigned NWORDS  = MAX_BITS / WORD_W,
    localparam int unsigned IDX_W   = (NWORDS > 1) ? $clog2(NWORDS) : 1,
    localparam int unsigned RES_W   = MAX_BITS + 1,
    localparam int unsigned MAG_W   = LAM_MAX - 1,
    localparam int unsigned LAM_W   = $clog2(LAM_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              start,
    input  logic [LAM_W-1:0]  mode_sel,
    input  logic              dig_req,
    output logic              dig_valid,
    output logic              dig_sign,
    output logic [MAG_W-1:0]  dig_mag,
    output logic              dig_last
);
    logic [RES_W-1:0] res;
    logic [RES_W-1:0] res_next;
    logic [LAM_W-1:0] lam;
    logic             calc_sign;
    logic [MAG_W-1:0] calc_mag;
    logic             wr_ok;
    logic             upd_en;
    logic             res_zero;

    assign res_zero = (res == '0);

    srec_digit_unit #(
        .RES_W  (RES_W),
        .LAM_MAX(LAM_MAX),
        .LAM_W  (LAM_W),
        .MAG_W  (MAG_W)
    ) digit_i (
        .res     (res),
        .lam     (lam),
        .dsign   (calc_sign),
        .dmag    (calc_mag),
        .res_next(res_next)
    );

    srec_residue #(
        .WORD_W(WORD_W),
        .NWORDS(NWORDS),
        .IDX_W (IDX_W),
        .RES_W (RES_W)
    ) residue_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_ok   (wr_ok && wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .upd_en  (upd_en),
        .res_next(res_next),
        .res     (res)
    );

    srec_ctrl #(
        .LAM_MAX(LAM_MAX),
        .LAM_W  (LAM_W),
        .MAG_W  (MAG_W)
    ) ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .mode_sel (mode_sel),
        .dig_req  (dig_req),
        .res_zero (res_zero),
        .calc_sign(calc_sign),
        .calc_mag (calc_mag),
        .lam      (lam),
        .wr_ok    (wr_ok),
        .upd_en   (upd_en),
        .dig_valid(dig_valid),
        .dig_sign (dig_sign),
        .dig_mag  (dig_mag),
        .dig_last (dig_last)
    );
endmodule

// File: rtl/srec_checker.sv
module srec_checker #(
    parameter int unsigned LAM_W = 3,
    parameter int unsigned MAG_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             dig_req,
    input logic             dig_valid,
    input logic             dig_sign,
    input logic [MAG_W-1:0] dig_mag,
    input logic             dig_last,
    input logic [LAM_W-1:0] lam
);
    logic [3:0] gap_q;
    logic       seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (dig_valid) begin
            if (dig_last) begin
                seen_q <= 1'b0;
                gap_q  <= '0;
            end else if (dig_mag != '0) begin
                seen_q <= 1'b1;
                gap_q  <= '0;
            end else if (gap_q != 4'hF) begin
                gap_q <= gap_q + 4'd1;
            end
        end
    end

    p_valid_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dig_valid |=> !dig_valid);

    p_valid_after_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dig_valid |-> $past(dig_req, 2));

    p_last_with_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dig_last |-> dig_valid);

    p_zero_unsigned_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dig_valid && dig_mag == '0) |-> !dig_sign);

    p_binary_digit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dig_valid && lam == LAM_W'(1)) |-> (!dig_sign && dig_mag <= MAG_W'(1)));

    p_naf_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dig_valid && lam > LAM_W'(1)) |-> ({1'b0, dig_mag} < ((MAG_W+1)'(1) << (lam - LAM_W'(1)))));

    p_naf_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (dig_valid && lam > LAM_W'(1) && dig_mag != '0 && seen_q) |-> (gap_q >= (4'(lam) - 4'd1)));
endmodule

bind scalar_recoder srec_checker #(
    .LAM_W(LAM_W),
    .MAG_W(MAG_W)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .dig_req  (dig_req),
    .dig_valid(dig_valid),
    .dig_sign (dig_sign),
    .dig_mag  (dig_mag),
    .dig_last (dig_last),
    .lam      (lam)
);

// File: tb/scalar_recoder_tb_top.sv
module scalar_recoder_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WORD_W   = 32;
    localparam int MAX_BITS = 256;
    localparam int NWORDS   = MAX_BITS / WORD_W;
    localparam int IDX_W    = $clog2(NWORDS);
    localparam int MAG_W    = 4;
    localparam int LAM_W    = 3;
    localparam int RW       = MAX_BITS + 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [IDX_W-1:0]  wr_idx = '0;
    logic [WORD_W-1:0] wr_data = '0;
    logic              start = 1'b0;
    logic [LAM_W-1:0]  mode_sel = '0;
    logic              dig_req = 1'b0;
    logic              dig_valid;
    logic              dig_sign;
    logic [MAG_W-1:0]  dig_mag;
    logic              dig_last;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    scalar_recoder dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .start    (start),
        .mode_sel (mode_sel),
        .dig_req  (dig_req),
        .dig_valid(dig_valid),
        .dig_sign (dig_sign),
        .dig_mag  (dig_mag),
        .dig_last (dig_last)
    );

    task automatic chk(input bit ok, input string tag, input logic [RW-1:0] act, input logic [RW-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    task automatic load_scalar(input logic [MAX_BITS-1:0] k);
        for (int w = 0; w < NWORDS; w++) begin
            @(negedge clk);
            wr_en   = 1'b1;
            wr_idx  = IDX_W'(w);
            wr_data = k[w*WORD_W +: WORD_W];
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Runs one full recoding and checks every digit against the model.
    task automatic run_case(input logic [MAX_BITS-1:0] k, input int code, input int disturb_at,
                            input string tag, output int ndig);
        logic [MAX_BITS:0]      r;
        logic signed [RW-1:0]   recon;
        logic signed [RW-1:0]   term;
        int lam, d, w, zrun, nz_seen;
        bit exp_last, got_last;
        load_scalar(k);
        @(negedge clk);
        start    = 1'b1;
        mode_sel = LAM_W'(code);
        @(negedge clk);
        start    = 1'b0;
        mode_sel = LAM_W'(0);
        lam   = (code >= 2 && code <= 5) ? code : 1;
        r     = {1'b0, k};
        recon = '0;
        ndig  = 0;
        zrun  = 0;
        nz_seen = 0;
        got_last = 0;
        while (!got_last && ndig <= MAX_BITS + 1) begin
            // model digit (R4, R5, R6)
            if (!r[0]) d = 0;
            else if (lam == 1) d = 1;
            else begin
                w = int'(r[4:0]) & ((1 << lam) - 1);
                d = (w >= (1 << (lam - 1))) ? w - (1 << lam) : w;
            end
            if (d < 0) r = r + (MAX_BITS+1)'(-d);
            else       r = r - (MAX_BITS+1)'(d);
            r = r >> 1;
            exp_last = (r == '0);
            // handshake (R7)
            dig_req = 1'b1;
            @(negedge clk);
            if (ndig == disturb_at) begin
                dig_req  = 1'b1;
                wr_en    = 1'b1;
                wr_idx   = '0;
                wr_data  = 32'h5A5A_F00D;
                start    = 1'b1;
                mode_sel = LAM_W'(lam == 1 ? 4 : 1);
            end else begin
                dig_req = 1'b0;
            end
            chk(dig_valid == 1'b0, {tag, " R7 valid low in CALC"}, RW'(dig_valid), '0);
            @(negedge clk);
            wr_en = 1'b0;
            start = 1'b0;
            mode_sel = '0;
            chk(dig_valid == 1'b1, {tag, " R7 valid two edges after request"}, RW'(dig_valid), RW'(1));
            chk(dig_sign == (d < 0), {tag, " R5 digit sign"}, RW'(dig_sign), RW'(d < 0));
            chk(dig_mag == MAG_W'(d < 0 ? -d : d), {tag, " R4 R5 R6 digit magnitude"},
                RW'(dig_mag), RW'(d < 0 ? -d : d));
            chk(dig_last == exp_last, {tag, " R8 last flag"}, RW'(dig_last), RW'(exp_last));
            if (lam > 1 && d != 0) begin
                if (nz_seen) chk(zrun >= lam - 1, {tag, " R9 zero gap"}, RW'(zrun), RW'(lam - 1));
                nz_seen = 1;
                zrun = 0;
            end else begin
                zrun++;
            end
            term  = RW'(d);
            term  = term <<< ndig;
            recon = recon + term;
            got_last = dig_last;
            ndig++;
            dig_req = 1'b0;
            @(negedge clk);
            chk(dig_valid == 1'b0, {tag, " R7 single-cycle valid, held request ignored"}, RW'(dig_valid), '0);
        end
        chk(ndig <= MAX_BITS + 1, {tag, " R8 digit count bound"}, RW'(ndig), RW'(MAX_BITS + 1));
        chk(recon == RW'({1'b0, k}), {tag, " R10 reconstruction"}, recon, RW'({1'b0, k}));
    endtask

    function automatic logic [MAX_BITS-1:0] gen(input int seed);
        logic [MAX_BITS-1:0] v;
        int unsigned s;
        s = seed;
        for (int i = 0; i < NWORDS; i++) begin
            s = s * 32'd1664525 + 32'd1013904223;
            v[i*WORD_W +: WORD_W] = s ^ (s >> 7);
        end
        return v;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        report();
    end

    initial begin
        int nd;
        logic [MAX_BITS-1:0] k;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(dig_valid == 1'b0, "R1 reset valid low", RW'(dig_valid), '0);
        chk(dig_last == 1'b0, "R1 reset last low", RW'(dig_last), '0);
        // request in IDLE gives nothing (R1)
        dig_req = 1'b1;
        @(negedge clk);
        dig_req = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(dig_valid == 1'b0, "R1 idle request ignored", RW'(dig_valid), '0);
        end

        run_case(gen(11), 1, -1, "binary", nd);
        k = gen(11);
        nd = 0;
        run_case(gen(23), 2, -1, "naf2", nd);
        run_case(gen(37), 3, -1, "naf3", nd);
        run_case(gen(41), 4, -1, "naf4", nd);
        run_case(gen(59), 5, -1, "naf5", nd);
        // R3: out-of-range codes fall back to binary
        run_case(gen(61), 0, -1, "R3 code0", nd);
        run_case(gen(67), 7, -1, "R3 code7", nd);
        // R8: zero scalar gives one zero digit flagged last
        run_case('0, 3, -1, "R8 zero", nd);
        chk(nd == 1, "R8 zero scalar digit count", RW'(nd), RW'(1));
        // R8: all ones under NAF-2 needs one extra digit
        run_case({MAX_BITS{1'b1}}, 2, -1, "R8 ones", nd);
        chk(nd == MAX_BITS + 1, "R8 all-ones digit count", RW'(nd), RW'(MAX_BITS + 1));
        // single top bit in binary: exactly MAX_BITS digits
        k = '0;
        k[MAX_BITS-1] = 1'b1;
        run_case(k, 1, -1, "R4 top bit", nd);
        chk(nd == MAX_BITS, "R4 top-bit digit count", RW'(nd), RW'(MAX_BITS));
        // R2, R11, R7: stray write, start and held request mid-run
        run_case(gen(71), 3, 5, "R2 R11 disturb naf3", nd);
        run_case(gen(73), 1, 0, "R2 R11 disturb binary", nd);
        report();
    end
endmodule